// File: doc/BRIEF.md
# Selectable Interleaved/Linear Burst Address Generator

This block produces the address sequence for a four-beat burst. When a burst begins, a load strobe captures a full start address. The low two bits seed the burst offset. The upper bits are held unchanged for the whole burst. After that, each rising clock edge at which the active-low advance input is low moves the burst on by one beat. The output is the held upper bits joined to the current offset.

A run-time mode input picks the ordering. With the mode input high, the offset for each beat is the start offset XORed with a beat index. This gives the interleaved order. With the mode input low, the offset is the start offset plus the beat index, wrapping modulo four. This gives the linear order. The ordering is the same for read bursts and write bursts, so the block has no direction input.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rstN low), and in the first cycle after it is released, burstAddr is all zeros.
- R2: In the cycle after a rising edge with loadStb high, burstAddr equals the startAddr sampled at that edge, in either mode. The beat index restarts at 0.
- R3: A load takes priority over advance. advN has no effect at an edge where loadStb is high, so the output after the load is the start address even when advN is low.
- R4: At a rising edge with loadStb low and advN low, the beat index advances by one, modulo 4.
- R5: At a rising edge with loadStb low and advN high, the beat index, the start offset and burstAddr hold their values.
- R6: With modeSel = 1 (interleaved), burstAddr[1:0] equals the start offset XOR the beat index. For example, start 01 yields 01, 00, 11, 10.
- R7: With modeSel = 0 (linear), burstAddr[1:0] equals (start offset + beat index) mod 4. For example, start 11 yields 11, 00, 01, 10.
- R8: After four advances the offset is back at the start offset, and further advances repeat the same four-beat cycle.
- R9: burstAddr bits above bit 1 equal the upper bits of the startAddr captured at the last load. Advances never change them.
- R10: modeSel is applied to the stored start offset and beat index without a register. Changing it mid-burst changes burstAddr in the same cycle and does not disturb the beat index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| loadStb | input | 1 | Captures startAddr and restarts the burst |
| advN | input | 1 | Advance, active low: steps one beat when low at an edge |
| modeSel | input | 1 | 1 = interleaved order, 0 = linear order |
| startAddr | input | ADDR_W | Burst start address |
| burstAddr | output | ADDR_W | Upper bits held from the load, joined to the current 2-bit offset |

## Verification
The bench builds the block with ADDR_W = 4, so two upper bits sit above the 2-bit offset. With only 16 start addresses, every start value is swept in both modes across eight beats, which checks both orderings and a full wrap for every combination of upper bits. The small width also lets the bench confirm that the upper bits never move during advances. The bench also covers a load with advance held low, idle hold cycles, and a mode flip in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes issued by the control block to the datapath each cycle
  typedef struct packed {
    logic load;   // capture start address, restart beat index
    logic step;   // advance beat index by one
  } ctrlStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadStb,
  input  logic         advN,
  output ctrlStrobes_t strb
);
  // Load wins; advance only counts when no load is present (R3, R4)
  always_comb begin
    strb.load = loadStb;
    strb.step = ~advN & ~loadStb;
  end

  assert_prio_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> (strb.load && !strb.step));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !advN) |-> strb.step);
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UP_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] startOff;
  logic [BEAT_W-1:0] beatCnt;
  logic [UP_W-1:0]   upperReg;
  logic [BEAT_W-1:0] curOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startOff <= '0;
      beatCnt  <= '0;
      upperReg <= '0;
    end else if (strb.load) begin
      startOff <= startAddr[BEAT_W-1:0];
      upperReg <= startAddr[ADDR_W-1:BEAT_W];
      beatCnt  <= '0;
    end else if (strb.step) begin
      beatCnt  <= beatCnt + ONE;
    end
  end

  // Ordering applied after the registers, so a mode change acts at once (R10)
  always_comb begin
    if (modeSel) curOff = startOff ^ beatCnt;  // interleaved (R6)
    else         curOff = startOff + beatCnt;  // linear, wraps (R7)
  end

  assign burstAddr = {upperReg, curOff};

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> beatCnt == $past(beatCnt) + ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(beatCnt) && $stable(startOff)));

  assert_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(upperReg));

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> beatCnt == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              advN,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  ctrlStrobes_t strb;

  burst_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .advN(advN), .strb(strb)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeSel(modeSel),
    .startAddr(startAddr), .burstAddr(burstAddr)
  );

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> burstAddr == $past(startAddr));

  assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> burstAddr[ADDR_W-1:BEAT_W] == $past(burstAddr[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN, loadStb, advN, modeSel;
  logic [AW-1:0] startAddr;
  logic [AW-1:0] burstAddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .advN(advN),
    .modeSel(modeSel), .startAddr(startAddr), .burstAddr(burstAddr)
  );

  function automatic logic [1:0] expOff(logic [1:0] s, int b, logic m);
    logic [1:0] bi;
    bi = 2'(b % 4);
    return m ? (s ^ bi) : 2'(s + bi);
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    compared++;
    if (burstAddr !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", req, burstAddr, exp);
    end
  endtask

  task automatic doLoad(logic [AW-1:0] a, logic adv);
    @(negedge clk);
    loadStb = 1'b1; startAddr = a; advN = adv;
    @(negedge clk);
    loadStb = 1'b0; advN = 1'b1;
  endtask

  task automatic doStep();
    advN = 1'b0;
    @(negedge clk);
    advN = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; loadStb = 1'b0; advN = 1'b1; modeSel = 1'b1; startAddr = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", '0);

    // Exhaustive sweep: both modes, all start addresses, two full wraps
    for (int m = 0; m < 2; m++) begin
      modeSel = m[0];
      for (int a = 0; a < (1 << AW); a++) begin
        doLoad(AW'(a), 1'b1);
        check("R2 load", AW'(a));
        for (int b = 1; b < 9; b++) begin
          doStep();
          check(m ? "R6 interleaved / R8 wrap / R9 upper" : "R7 linear / R8 wrap / R9 upper",
                {2'(a >> 2), expOff(2'(a), b, m[0])});
        end
      end
    end

    // Load with advance held low: advance ignored
    modeSel = 1'b0;
    doLoad(4'b1010, 1'b0);
    check("R3 load priority", 4'b1010);

    // Hold: advance high for several cycles
    doStep();
    check("R4 single step", 4'b1011);
    repeat (3) @(negedge clk);
    check("R5 hold", 4'b1011);

    // Mode flip mid-burst: start 01, beat 1
    modeSel = 1'b1;
    doLoad(4'b0101, 1'b1);
    doStep();
    check("R6 interleaved beat1", 4'b0100);
    modeSel = 1'b0;
    #1;
    check("R10 mode flip same cycle", 4'b0110);
    @(negedge clk);
    check("R10 beat index kept", 4'b0110);
    doStep();
    check("R10 continue linear", 4'b0111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule